// File: doc/BRIEF.md
# Bidirectional Interface Latch Bank

This block keeps a small bank of general-purpose latches that connect to the control leads of a line-interface circuit. Each latch has its own direction bit. A latch set as an output drives its pad with a value programmed through the control port. A latch set as an input holds a snapshot of its pad. That snapshot is taken only when the control port accepts a byte, and never continuously.

The block sits behind a control-port decoder. The decoder gives it three single-cycle strobes: a direction-register write, a latch-data write, and a general strobe for any accepted control byte. With these strobes comes one shared write byte. Two read-back bytes are always valid. They give the direction bits and the latch contents, so sensed inputs and programmed outputs appear side by side. A parameter can build a bank in which the highest latches have no pad. Such latches are held as outputs so they never float.

Top module: `io_latch_bank`

## Requirements
- R1: After reset every latch with a pad is an input: `pin_oe` and `pin_out` are all zero, `dat_rd` is zero, and `dir_rd` is zero apart from the forced lanes of R10.
- R2: Latch i uses byte bit 7-i in every byte (write byte, `dir_rd`, `dat_rd`). A `dir_wr` strobe loads the direction bits, where 1 means output and 0 means input. Bits 1..0 of the write byte are ignored and always read back as 0.
- R3: On a `dat_wr` strobe, each latch that is already an output stores its write-byte bit. `pin_out` then shows that value with `pin_oe` high from the next cycle.
- R4: A `dat_wr` strobe never places write-byte data into a latch that is an input.
- R5: On a `ctl_wr` strobe, each input latch stores its `pin_in` level. Without the strobe, pad changes do not reach `dat_rd`.
- R6: A `ctl_wr` strobe on its own leaves every output latch unchanged.
- R7: `dat_rd` returns the stored value of every latch: sampled levels for inputs and programmed values for outputs.
- R8: With no strobe, all latch values, directions and pad outputs hold indefinitely, including while the surrounding device is powered down.
- R9: When `dir_wr` and `dat_wr` are asserted in the same cycle, the data write uses the directions that were in force before that cycle.
- R10: A latch whose index is PADS or above reads back as an output, never asserts `pin_oe` and never samples its pad, but still stores written data.
- R11: When an output latch becomes an input, its `pin_oe` and `pin_out` drop to 0 and its stored value is kept until the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_wr | input | 1 | Direction-register write strobe |
| dat_wr | input | 1 | Latch-data write strobe |
| ctl_wr | input | 1 | Strobe for any accepted control byte (pad sampling) |
| wr_byte | input | BYTE_W | Shared write data |
| pin_in | input | LATCH_N | Pad input levels |
| pin_out | output | LATCH_N | Pad output values |
| pin_oe | output | LATCH_N | Pad output enables |
| dat_rd | output | BYTE_W | Latch contents read-back byte |
| dir_rd | output | BYTE_W | Direction read-back byte |

## Verification
The bench goes through all 64 direction patterns, both with a data write and with a pad sample. A design that reversed the bit order, or that read data into input latches, would give wrong read-back bytes. A design that sampled pads continuously would show pad changes made with no strobe present. Another corner is a direction write and a data write in the same cycle. A design that used the new directions there would store or drop the wrong bits. Turning an output back into an input must release the pad but keep the stored value. A bank without a top pad is checked to confirm that this lane neither floats nor samples.

// File: rtl/iolb_pkg.sv
package iolb_pkg;
  localparam int MAX_BYTE_W = 8;

  // Byte bit position that carries latch lane i (lane 0 is the byte MSB).
  function automatic int lane_bitpos(input int byte_w, input int lane);
    return byte_w - 1 - lane;
  endfunction

  // Place a lane vector into a byte, MSB-first, with unused low bits zero.
  function automatic logic [MAX_BYTE_W-1:0] lanes_to_byte(
      input logic [MAX_BYTE_W-1:0] lanes, input int n_lanes, input int byte_w);
    logic [MAX_BYTE_W-1:0] b;
    b = '0;
    for (int i = 0; i < MAX_BYTE_W; i++) begin
      if (i < n_lanes) b[lane_bitpos(byte_w, i)] = lanes[i];
    end
    return b;
  endfunction

  // Pick lane values out of a byte, MSB-first.
  function automatic logic [MAX_BYTE_W-1:0] byte_to_lanes(
      input logic [MAX_BYTE_W-1:0] b, input int n_lanes, input int byte_w);
    logic [MAX_BYTE_W-1:0] v;
    v = '0;
    for (int i = 0; i < MAX_BYTE_W; i++) begin
      if (i < n_lanes) v[i] = b[lane_bitpos(byte_w, i)];
    end
    return v;
  endfunction
endpackage

// File: rtl/iolb_cell.sv
module iolb_cell #(
  parameter bit HAS_PAD = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_wr,
  input  logic dat_wr,
  input  logic ctl_wr,
  input  logic dir_bit,
  input  logic dat_bit,
  input  logic pin_i,
  output logic pin_o,
  output logic pin_en,
  output logic dir_q_o,
  output logic lat_q_o
);
  logic dir_q;
  logic lat_q;
  logic take_data;
  logic take_pin;

  generate
    if (HAS_PAD) begin : g_pad
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir_q <= 1'b0;
        else if (dir_wr) dir_q <= dir_bit;
      end
      // R2: direction bit loads from the write byte
      p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> dir_q == $past(dir_bit));
    end else begin : g_nopad
      // R10: lane without a pad is held as an output
      assign dir_q = 1'b1;
    end
  endgenerate

  // Old direction governs a same-cycle data write (R9).
  assign take_data = dat_wr & dir_q;
  assign take_pin  = ctl_wr & ~dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lat_q <= 1'b0;
    else if (take_data) lat_q <= dat_bit;
    else if (take_pin)  lat_q <= pin_i;
  end

  assign pin_en  = HAS_PAD & dir_q;
  assign pin_o   = pin_en & lat_q;
  assign dir_q_o = dir_q;
  assign lat_q_o = lat_q;

  p_data_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_data |=> lat_q == $past(dat_bit));
  p_pin_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_pin |=> lat_q == $past(pin_i));
  p_out_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q && ctl_wr && !dat_wr) |=> $stable(lat_q));
  p_input_no_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_q && dat_wr && !ctl_wr) |=> $stable(lat_q));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dat_wr && !ctl_wr) |=> $stable(lat_q));
endmodule

// File: rtl/iolb_pack.sv
module iolb_pack #(
  parameter int LATCH_N = 6,
  parameter int BYTE_W  = 8
) (
  input  logic [LATCH_N-1:0] lanes,
  output logic [BYTE_W-1:0]  byte_o
);
  import iolb_pkg::*;
  logic [MAX_BYTE_W-1:0] wide_lanes;
  logic [MAX_BYTE_W-1:0] wide_byte;

  always_comb begin
    wide_lanes = '0;
    wide_lanes[LATCH_N-1:0] = lanes;
    wide_byte = lanes_to_byte(wide_lanes, LATCH_N, BYTE_W);
  end
  assign byte_o = wide_byte[BYTE_W-1:0];
endmodule

// File: rtl/io_latch_bank.sv
module io_latch_bank #(
  parameter int LATCH_N = 6,
  parameter int PADS    = 6,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dir_wr,
  input  logic               dat_wr,
  input  logic               ctl_wr,
  input  logic [BYTE_W-1:0]  wr_byte,
  input  logic [LATCH_N-1:0] pin_in,
  output logic [LATCH_N-1:0] pin_out,
  output logic [LATCH_N-1:0] pin_oe,
  output logic [BYTE_W-1:0]  dat_rd,
  output logic [BYTE_W-1:0]  dir_rd
);
  import iolb_pkg::*;

  logic [MAX_BYTE_W-1:0] wide_wr;
  logic [MAX_BYTE_W-1:0] wr_lanes_w;
  logic [LATCH_N-1:0]    wr_lanes;
  logic [LATCH_N-1:0]    dir_v;
  logic [LATCH_N-1:0]    lat_v;

  always_comb begin
    wide_wr = '0;
    wide_wr[BYTE_W-1:0] = wr_byte;
    wr_lanes_w = byte_to_lanes(wide_wr, LATCH_N, BYTE_W);
  end
  assign wr_lanes = wr_lanes_w[LATCH_N-1:0];

  generate
    for (genvar i = 0; i < LATCH_N; i++) begin : g_lane
      iolb_cell #(.HAS_PAD(i < PADS)) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_wr  (dir_wr),
        .dat_wr  (dat_wr),
        .ctl_wr  (ctl_wr),
        .dir_bit (wr_lanes[i]),
        .dat_bit (wr_lanes[i]),
        .pin_i   (pin_in[i]),
        .pin_o   (pin_out[i]),
        .pin_en  (pin_oe[i]),
        .dir_q_o (dir_v[i]),
        .lat_q_o (lat_v[i])
      );
    end
  endgenerate

  iolb_pack #(.LATCH_N(LATCH_N), .BYTE_W(BYTE_W)) u_dat_pack (
    .lanes (lat_v), .byte_o (dat_rd));
  iolb_pack #(.LATCH_N(LATCH_N), .BYTE_W(BYTE_W)) u_dir_pack (
    .lanes (dir_v), .byte_o (dir_rd));

  p_oe_only_on_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(pin_oe));
  p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_wr && !dat_wr && !ctl_wr) |=> ($stable(dat_rd) && $stable(dir_rd)));
endmodule

// File: tb/test_io_latch_bank.sv
module test_io_latch_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_wr = 1'b0, dat_wr = 1'b0, ctl_wr = 1'b0;
  logic [7:0] wr_byte = '0;
  logic [5:0] pin_in = '0;
  logic [5:0] out6, oe6, out5, oe5;
  logic [7:0] drd6, dird6, drd5, dird5;
  int checks = 0;
  int failures = 0;
  logic [5:0] mdir [2];
  logic [5:0] mlat [2];
  int pads [2];

  always #5 clk = ~clk;

  io_latch_bank i_io_latch_bank (
    .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .dat_wr(dat_wr), .ctl_wr(ctl_wr),
    .wr_byte(wr_byte), .pin_in(pin_in), .pin_out(out6), .pin_oe(oe6),
    .dat_rd(drd6), .dir_rd(dird6));

  io_latch_bank #(.PADS(5)) i_io_latch_bank_five (
    .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .dat_wr(dat_wr), .ctl_wr(ctl_wr),
    .wr_byte(wr_byte), .pin_in(pin_in), .pin_out(out5), .pin_oe(oe5),
    .dat_rd(drd5), .dir_rd(dird5));

  function automatic logic [7:0] to_byte(input logic [5:0] v);
    logic [7:0] b = 8'h00;
    for (int i = 0; i < 6; i++) b = b | ({7'd0, v[i]} << (7 - i));
    return b;
  endfunction

  function automatic logic [5:0] from_byte(input logic [7:0] b);
    logic [5:0] v = '0;
    for (int i = 0; i < 6; i++) v[i] = b[7 - i];
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] got,
                     input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 2; k++) begin
      logic [5:0] hp, oe_e, out_e;
      hp = (pads[k] >= 6) ? 6'h3F : 6'h1F;
      oe_e  = mdir[k] & hp;
      out_e = oe_e & mlat[k];
      if (k == 0) begin
        chk(tag, "oe6", {2'b0, oe6}, {2'b0, oe_e});
        chk(tag, "out6", {2'b0, out6}, {2'b0, out_e});
        chk(tag, "dat6", drd6, to_byte(mlat[k]));
        chk(tag, "dir6", dird6, to_byte(mdir[k]));
      end else begin
        chk(tag, "oe5", {2'b0, oe5}, {2'b0, oe_e});
        chk(tag, "out5", {2'b0, out5}, {2'b0, out_e});
        chk(tag, "dat5", drd5, to_byte(mlat[k]));
        chk(tag, "dir5", dird5, to_byte(mdir[k]));
      end
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      mlat[k] = '0;
      mdir[k] = (pads[k] >= 6) ? 6'h00 : 6'h20;
    end
  endtask

  task automatic step(input logic dw, input logic tw, input logic cw,
                      input logic [7:0] b, input logic [5:0] p);
    logic [5:0] wl;
    dir_wr = dw; dat_wr = tw; ctl_wr = cw; wr_byte = b; pin_in = p;
    @(posedge clk);
    wl = from_byte(b);
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 6; i++) begin
        if (tw && mdir[k][i]) mlat[k][i] = wl[i];
        else if (cw && !mdir[k][i]) mlat[k][i] = p[i];
      end
      if (dw) mdir[k] = (pads[k] >= 6) ? wl : (wl | 6'h20);
    end
    @(negedge clk);
    dir_wr = 1'b0; dat_wr = 1'b0; ctl_wr = 1'b0;
    #1;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    pads[0] = 6; pads[1] = 5;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state, lane 5 of the five-pad bank reads as output (R10)
    chk("R1", "dir6 reset", dird6, 8'h00);
    chk("R10", "dir5 reset", dird5, 8'h04);
    chk("R1", "oe6 reset", {2'b0, oe6}, 8'h00);
    chk("R1", "dat6 reset", drd6, 8'h00);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check_all("R1");

    // R8: pads move with no strobe, nothing changes
    step(1'b0, 1'b0, 1'b0, 8'hFF, 6'h3F);
    check_all("R8");
    chk("R8", "dat6 idle", drd6, 8'h00);

    // R5: sample on control strobe, all inputs
    step(1'b0, 1'b0, 1'b1, 8'h00, 6'b101101);
    check_all("R5");
    chk("R5", "dat6 sampled", drd6, 8'hB4);
    step(1'b0, 1'b0, 1'b0, 8'h00, 6'b010010);
    chk("R5", "dat6 no resample", drd6, 8'hB4);
    // R4: data write with input directions stores no data
    step(1'b0, 1'b1, 1'b0, 8'hFC, 6'b000000);
    chk("R4", "dat6 data ignored", drd6, 8'hB4);
    check_all("R4");

    // R2/R3/R7 sweep over every direction pattern
    for (int d = 0; d < 64; d++) begin
      logic [5:0] dv, data_v, pin_v;
      dv = d[5:0];
      data_v = ~dv ^ 6'h15;
      pin_v  = dv ^ 6'h2A;
      step(1'b1, 1'b0, 1'b0, to_byte(dv) | 8'h03, 6'h00);
      check_all("R2");
      step(1'b0, 1'b1, 1'b1, to_byte(data_v) | 8'h02, pin_v);
      check_all("R3");
      step(1'b0, 1'b0, 1'b1, 8'h00, ~pin_v);
      check_all("R7");
    end

    // R6: outputs ignore a pad sample
    step(1'b1, 1'b0, 1'b0, 8'hFC, 6'h00);
    step(1'b0, 1'b1, 1'b1, 8'hA8, 6'h00);
    chk("R3", "out6 pattern", {2'b0, out6}, {2'b0, 6'b010101});
    step(1'b0, 1'b0, 1'b1, 8'h00, 6'h3F);
    chk("R6", "dat6 kept", drd6, 8'hA8);
    check_all("R6");

    // R9: same-cycle direction and data write use old directions
    step(1'b1, 1'b0, 1'b0, 8'hE0, 6'h00);       // lanes 0..2 out
    step(1'b1, 1'b1, 1'b1, 8'h1C, 6'h00);       // new dir lanes 3..5, data to 0..2 only
    check_all("R9");
    chk("R9", "dat6 old-dir write", drd6, 8'h00);

    // R11: output turned input releases the pad and keeps its value
    step(1'b1, 1'b0, 1'b0, 8'hFC, 6'h00);
    step(1'b0, 1'b1, 1'b0, 8'hFC, 6'h00);
    step(1'b1, 1'b0, 1'b0, 8'h00, 6'h00);
    chk("R11", "oe6 released", {2'b0, oe6}, 8'h00);
    chk("R11", "out6 released", {2'b0, out6}, 8'h00);
    chk("R11", "dat6 kept", drd6, 8'hFC);
    check_all("R11");

    // R10: padless lane stays output, no enable, no sampling, stores data
    chk("R10", "dir5 forced", dird5, 8'h04);
    chk("R10", "oe5 lane5", {7'd0, oe5[5]}, 8'h00);
    step(1'b0, 1'b0, 1'b1, 8'h00, 6'h00);
    chk("R10", "dat5 lane5 not sampled", {7'd0, drd5[2]}, 8'h01);
    check_all("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule